// File: doc/BRIEF.md
# Quad-Channel Parallel Converter Bus Sequencer

This block sits on the host side of a four-channel parallel digital-to-analog converter. A host asks for one operation at a time through a small request port: an operation code, a two-bit channel, a 12-bit word and a start pulse. The block then drives the converter's address, read/write line, active-low select, 12-bit data bus with its own output enable, active-low global load strobe and active-low clear line. Each phase lasts a number of clock cycles. These counts are derived from nanosecond limits and the `CLK_PERIOD_NS` parameter, rounding up.

A write can end there. It can also be followed by a delayed pulse on the load strobe, which moves every channel's staged word to its output together. A read holds the select low long enough for the converter's data to become valid. It captures the bus into `rdata` at that point and then keeps the host's drivers off the bus until the converter has let go of it. A clear operation pulses the clear line alone. `busy` covers the whole operation and `done` marks its end.

Top module: `dac_bus_seq`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_ld_n` and `bus_clr_n` are 1, `bus_rnw` is 1, `bus_oe` is 0, and `busy` and `done` are 0.
- R2: Operation codes are 2'b00 plain write, 2'b01 write then load pulse, 2'b10 read, 2'b11 clear pulse. A write holds `bus_cs_n` low for exactly ceil(50 ns / period) cycles, which is 13 at a 4 ns period.
- R3: While `bus_cs_n` is low for a write, `bus_addr` equals the requested channel, `bus_dout` the requested word, `bus_rnw` is 0 and `bus_oe` is 1, and none of them changes.
- R4: A read holds `bus_cs_n` low for exactly ceil(200 ns / period) cycles, which is 50 at 4 ns. `bus_rnw` is 1 for at least ceil(10 ns / period) cycles before the select falls and after it rises.
- R5: A read captures `bus_din` into `rdata` on the clock edge that ends the ceil(160 ns / period)-th low cycle of the select, which is the 40th at 4 ns. `bus_oe` stays 0 for the whole read.
- R6: For opcode 2'b01, `bus_ld_n` falls no sooner than ceil(10 ns / period) cycles after `bus_cs_n` rises. It then stays low for exactly ceil(50 ns / period) cycles. `bus_ld_n` never goes low for any other opcode.
- R7: After a read, `bus_oe` stays 0 until at least ceil(100 ns / period) cycles after `bus_cs_n` rose.
- R8: Opcode 2'b11 drives `bus_clr_n` low for exactly ceil(50 ns / period) cycles and leaves `bus_cs_n` high. No two of select, load strobe and clear are low at once.
- R9: `start` while `busy` is 1 is ignored: no further bus transaction follows.
- R10: `done` is high for exactly one cycle at the end of every operation, and `busy` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Operation code, sampled with start |
| ch | input | 2 | Channel number, sampled with start |
| wdata | input | 12 | Word to write, sampled with start |
| start | input | 1 | Request pulse, honoured only while idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | 12 | Word captured by the last read |
| bus_addr | output | 2 | Channel select to the converter |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_dout | output | 12 | Data driven toward the converter |
| bus_oe | output | 1 | Host bus driver enable |
| bus_din | input | 12 | Data returned by the converter |
| bus_ld_n | output | 1 | Active-low global load strobe |
| bus_clr_n | output | 1 | Active-low converter clear |

## Verification
The assertions assume that the bench holds `op`, `ch` and `wdata` steady in the cycle it raises `start`. They assume `rst_n` is released only between clock edges. The bench changes inputs only on falling clock edges and gives each request a single-cycle start pulse. Its converter model returns a wrong word on `bus_din` until the 40th low cycle of a read select. A capture taken one cycle early is therefore visible on `rdata`. One test issues a write directly after a read to exercise the bus release wait.

// File: rtl/dac_bus_seq.sv
module dac_bus_seq #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int DW = 12,
  parameter int AW = 2,
  parameter int WR_CS_NS = 50,
  parameter int RD_CS_NS = 200,
  parameter int RD_VALID_NS = 160,
  parameter int RNW_SETUP_NS = 10,
  parameter int RNW_HOLD_NS = 10,
  parameter int WR_SETUP_NS = 0,
  parameter int WR_HOLD_NS = 0,
  parameter int RELEASE_NS = 100,
  parameter int LD_DELAY_NS = 10,
  parameter int LD_WIDTH_NS = 50,
  parameter int CLR_WIDTH_NS = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op,
  input  logic [AW-1:0] ch,
  input  logic [DW-1:0] wdata,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic          bus_cs_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_ld_n,
  output logic          bus_clr_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int T_WCS = cyc(WR_CS_NS);
  localparam int T_RCS = cyc(RD_CS_NS);
  localparam int T_RDV = cyc(RD_VALID_NS);
  localparam int T_RWS = cyc(RNW_SETUP_NS);
  localparam int T_RWH = cyc(RNW_HOLD_NS);
  localparam int T_WS  = cyc(WR_SETUP_NS);
  localparam int T_WH  = cyc(WR_HOLD_NS);
  localparam int T_REL = cyc(RELEASE_NS);
  localparam int T_LD  = cyc(LD_DELAY_NS);
  localparam int T_LW  = cyc(LD_WIDTH_NS);
  localparam int T_CLR = cyc(CLR_WIDTH_NS);
  localparam int CW = 16;

  localparam logic [1:0] OP_WR = 2'b00, OP_WRLD = 2'b01, OP_RD = 2'b10, OP_CLR = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SETUP, S_CSLOW, S_HOLD, S_LDGAP, S_LDLOW, S_CLR} state_t;

  state_t st, st_nx;
  logic [CW-1:0] cnt, rel, len;
  logic [1:0] op_q;
  logic [AW-1:0] ch_q;
  logic [DW-1:0] wd_q;
  logic rd, last;

  assign rd = (op_q == OP_RD);

  always_comb begin
    case (st)
      S_SETUP: len = CW'(rd ? T_RWS : T_WS);
      S_CSLOW: len = CW'(rd ? T_RCS : T_WCS);
      S_HOLD:  len = CW'(rd ? T_RWH : T_WH);
      S_LDGAP: len = CW'(T_LD);
      S_LDLOW: len = CW'(T_LW);
      S_CLR:   len = CW'(T_CLR);
      default: len = CW'(1);
    endcase
  end

  assign last = (cnt == len - CW'(1));

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start) st_nx = S_WAIT;
      S_WAIT:  if (op_q == OP_CLR) st_nx = S_CLR;
               else if (rd || rel == '0) st_nx = S_SETUP;
      S_SETUP: if (last) st_nx = S_CSLOW;
      S_CSLOW: if (last) st_nx = S_HOLD;
      S_HOLD:  if (last) st_nx = (op_q == OP_WRLD) ? S_LDGAP : S_IDLE;
      S_LDGAP: if (last) st_nx = S_LDLOW;
      S_LDLOW: if (last) st_nx = S_IDLE;
      S_CLR:   if (last) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      rel <= '0;
      done <= 1'b0;
      op_q <= OP_WR;
      ch_q <= '0;
      wd_q <= '0;
      rdata <= '0;
    end else begin
      st <= st_nx;
      cnt <= (st_nx != st) ? '0 : cnt + CW'(1);
      done <= (st != S_IDLE) && (st_nx == S_IDLE);
      if (st == S_IDLE && start) begin
        op_q <= op;
        ch_q <= ch;
        wd_q <= wdata;
      end
      if (st == S_CSLOW && rd && cnt == CW'(T_RDV - 1)) rdata <= bus_din;
      if (st == S_CSLOW && rd && last) rel <= CW'(T_REL);
      else if (rel != '0) rel <= rel - CW'(1);
    end
  end

  logic in_xfer;
  assign in_xfer   = (st == S_SETUP) || (st == S_CSLOW) || (st == S_HOLD);
  assign busy      = (st != S_IDLE);
  assign bus_addr  = ch_q;
  assign bus_dout  = wd_q;
  assign bus_cs_n  = (st != S_CSLOW);
  assign bus_rnw   = !(in_xfer && !rd);
  assign bus_oe    = in_xfer && !rd;
  assign bus_ld_n  = (st != S_LDLOW);
  assign bus_clr_n = (st != S_CLR);

endmodule

module dac_bus_seq_chk #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int DW = 12,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          bus_cs_n,
  input logic          bus_rnw,
  input logic          bus_oe,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_ld_n,
  input logic          bus_clr_n
);
  localparam int WMIN = (50 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int LMIN = (50 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  int cs_low, ld_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low <= 0;
      ld_low <= 0;
    end else begin
      cs_low <= bus_cs_n ? 0 : cs_low + 1;
      ld_low <= bus_ld_n ? 0 : ld_low + 1;
    end
  end

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_dout) && $stable(bus_rnw) && $stable(bus_oe))); // R3
  AST_CS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (cs_low >= WMIN)); // R2
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_rnw); // R5
  AST_LD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ld_n) |-> (ld_low >= LMIN)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!bus_cs_n, !bus_ld_n, !bus_clr_n})); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind dac_bus_seq dac_bus_seq_chk #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .bus_cs_n(bus_cs_n), .bus_rnw(bus_rnw),
  .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_ld_n(bus_ld_n),
  .bus_clr_n(bus_clr_n)
);

// File: tb/dac_bus_seq_test.sv
module dac_bus_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op = 2'b00;
  logic [1:0] ch = 2'b00;
  logic [11:0] wdata = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [11:0] rdata;
  logic [1:0] bus_addr;
  logic bus_rnw, bus_cs_n, bus_oe, bus_ld_n, bus_clr_n;
  logic [11:0] bus_dout;
  logic [11:0] bus_din;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dac_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .op(op), .ch(ch), .wdata(wdata), .start(start),
    .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_cs_n(bus_cs_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .bus_ld_n(bus_ld_n), .bus_clr_n(bus_clr_n)
  );

  // converter model and bus monitor, both sampled on falling edges
  logic [11:0] good_word = 12'hA5C;
  int rd_low = 0;
  int cs_run = 0, cs_len = 0, cs_pulses = 0;
  int ld_run = 0, ld_len = 0, ld_pulses = 0;
  int clr_run = 0, clr_len = 0;
  int since_cs_rise = 0, ld_gap = -1, oe_gap = -1;
  int rnw_hi = 0, rnw_setup = -1, rnw_after = 0, rnw_hold = -1;
  int done_run = 0, done_len = 0;
  bit stable_bad = 0, oe_in_read = 0, busy_after_done = 0;
  bit prev_cs_n = 1, prev_ld_n = 1, prev_oe = 0, prev_done = 0, last_was_read = 0;
  logic [1:0] prev_addr; logic [11:0] prev_dout; logic prev_rnw;

  assign bus_din = (rd_low >= 40) ? good_word : ~good_word;

  always @(negedge clk) begin
    rd_low <= (!bus_cs_n && bus_rnw) ? rd_low + 1 : 0;
    if (!bus_cs_n) begin
      if (prev_cs_n) begin
        cs_pulses <= cs_pulses + 1;
        rnw_setup <= rnw_hi;
        last_was_read <= bus_rnw;
      end
      cs_run <= cs_run + 1;
      if (!prev_cs_n && (bus_addr != prev_addr || bus_dout != prev_dout || bus_rnw != prev_rnw)) stable_bad <= 1;
      if (bus_rnw && bus_oe) oe_in_read <= 1;
      since_cs_rise <= 0;
    end else begin
      if (!prev_cs_n) begin cs_len <= cs_run; rnw_after <= 0; end
      cs_run <= 0;
      since_cs_rise <= since_cs_rise + 1;
    end
    if (bus_cs_n && !prev_cs_n) rnw_after <= bus_rnw ? 1 : 0;
    else if (bus_cs_n && bus_rnw && rnw_after > 0) rnw_after <= rnw_after + 1;
    else if (bus_cs_n && !bus_rnw && rnw_after > 0) begin rnw_hold <= rnw_after; rnw_after <= 0; end
    rnw_hi <= bus_rnw ? rnw_hi + 1 : 0;
    if (!bus_ld_n) begin
      if (prev_ld_n) begin ld_pulses <= ld_pulses + 1; ld_gap <= since_cs_rise + 1; end
      ld_run <= ld_run + 1;
    end else begin
      if (!prev_ld_n) ld_len <= ld_run;
      ld_run <= 0;
    end
    if (!bus_clr_n) clr_run <= clr_run + 1;
    else begin if (clr_run > 0) clr_len <= clr_run; clr_run <= 0; end
    if (bus_oe && !prev_oe && last_was_read) oe_gap <= since_cs_rise + 1;
    if (done) done_run <= done_run + 1;
    else begin if (done_run > 0) done_len <= done_run; done_run <= 0; end
    if (prev_done && busy) busy_after_done <= 1;
    prev_cs_n <= bus_cs_n; prev_ld_n <= bus_ld_n; prev_oe <= bus_oe; prev_done <= done;
    prev_addr <= bus_addr; prev_dout <= bus_dout; prev_rnw <= bus_rnw;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [1:0] c, input logic [11:0] d);
    @(negedge clk);
    op = o; ch = c; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check(bus_cs_n && bus_ld_n && bus_clr_n, "R1 strobes idle", {bus_cs_n, bus_ld_n, bus_clr_n}, 7);
    check(bus_rnw && !bus_oe, "R1 rnw/oe", {bus_rnw, bus_oe}, 2);
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
  endtask

  task automatic t_write;
    int p = cs_pulses, l = ld_pulses;
    stable_bad = 0;
    fork
      begin
        wait (!bus_cs_n);
        @(negedge clk);
        check(bus_addr == 2'd2 && bus_dout == 12'h3C1 && !bus_rnw && bus_oe, "R3 write fields",
              {bus_addr, bus_dout}, {2'd2, 12'h3C1});
      end
      issue(2'b00, 2'd2, 12'h3C1);
    join
    check(cs_pulses == p + 1, "R2 one select pulse", cs_pulses - p, 1);
    check(cs_len == 13, "R2 write select width", cs_len, 13);
    check(!stable_bad, "R3 fields stable", stable_bad, 0);
    check(ld_pulses == l, "R6 no load on plain write", ld_pulses - l, 0);
    check(done_len == 1 && !busy_after_done, "R10 done pulse", done_len, 1);
  endtask

  task automatic t_write_load;
    issue(2'b01, 2'd1, 12'hFFF);
    check(ld_len == 13, "R6 load width", ld_len, 13);
    check(ld_gap >= 4, "R6 load delay", ld_gap, 4);
    check(cs_len == 13, "R2 write select width with load", cs_len, 13);
  endtask

  task automatic t_read_then_write;
    oe_in_read = 0;
    good_word = 12'h5A3;
    issue(2'b10, 2'd3, 12'h000);
    check(cs_len == 50, "R4 read select width", cs_len, 50);
    check(rnw_setup >= 3, "R4 rnw setup", rnw_setup, 3);
    check(rdata == 12'h5A3, "R5 read capture", rdata, 12'h5A3);
    check(!oe_in_read, "R5 oe off in read", oe_in_read, 0);
    // write issued right after a read: release wait
    good_word = 12'h0F0;
    @(negedge clk);
    op = 2'b10; ch = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    op = 2'b00; ch = 2'd1; wdata = 12'h123; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    check(rnw_hold >= 3, "R4 rnw hold", rnw_hold, 3);
    check(oe_gap >= 26, "R7 release wait", oe_gap, 26);
    check(rdata == 12'h0F0, "R5 second read capture", rdata, 12'h0F0);
  endtask

  task automatic t_clear;
    int p = cs_pulses;
    issue(2'b11, 2'd0, 12'h000);
    check(clr_len == 13, "R8 clear width", clr_len, 13);
    check(cs_pulses == p, "R8 no select in clear", cs_pulses - p, 0);
  endtask

  task automatic t_start_busy;
    int p = cs_pulses;
    @(negedge clk);
    op = 2'b00; ch = 2'd0; wdata = 12'h777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    op = 2'b10; ch = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (100) @(negedge clk);
    check(cs_pulses == p + 1, "R9 start while busy ignored", cs_pulses - p, 1);
    check(!busy, "R9 idle afterwards", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_write_load();
    t_read_then_write();
    t_clear();
    t_start_busy();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule